// File: doc/BRIEF.md
# Ping-Pong Packet Write Master

This block sits between a producer of formatted data words and a host memory. It accepts one word at a time over a valid/ready handshake and writes each word, once, into external memory through a memory-mapped master port that uses a waitrequest flow-control signal. Every transfer is a single word with all byte lanes enabled.

The target region holds two packet-sized buffers. The block fills them in alternation, so the host can read one while the block writes the other. When a buffer has received its last word, the block raises an interrupt and reports which buffer is ready. The interrupt stays up until the host acknowledges it. If the host falls behind and both buffers are still unacknowledged, the block stops taking data upstream and latches an overflow flag. It never overwrites a buffer that the host has not released.

Top module: `pingpong_wr_master`

## Requirements
- R1: After reset, `memWrite`, `irq` and `overflow` are 0. `inReady` equals `enable`.
- R2: The word with index i in buffer b (b is 0 or 1, i counts from 0 up to PKT_WORDS-1) is written at `baseAddr | ((b*PKT_WORDS + i) * DATA_W/8)`. Consecutive words therefore step by DATA_W/8 bytes. Buffer 0 is filled first, and the two buffers then alternate.
- R3: While `memWrite` is 1, `memByteEn` is all ones and `memBurst` equals 1.
- R4: While `memWrite` and `memWait` are both 1, the block holds `memWrite`, `memAddr` and `memWrData` unchanged into the next cycle.
- R5: A bus write is accepted on a clock where `memWrite` is 1 and `memWait` is 0. Each word taken upstream (`inValid` and `inReady` both 1) produces exactly one accepted write, carrying that word and in arrival order. `memWrite` drops after an acceptance when no new word is taken in the same cycle.
- R6: `inReady` is 1 only when `enable` is 1, the buffer that the next word targets is not full, and no write is pending or the pending write is accepted in that cycle.
- R7: A buffer becomes full when its last word is accepted. `irq` is 1 in the following cycle, and stays 1 for as long as any buffer is full.
- R8: `irqBuf` names the oldest full buffer. A 1 on `irqAck` while `irq` is 1 releases that buffer. A 1 on `irqAck` while `irq` is 0 has no effect.
- R9: While both buffers are full, `inReady` is 0. If `inValid` is 1 in such a cycle, `overflow` becomes 1 and stays 1 until reset.
- R10: A synchronous reset in mid-run returns the block to buffer 0, index 0. It also clears every full mark, the pending write and the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Start (1) or stop (0) taking words |
| baseAddr | input | ADDR_W | Byte address of buffer 0; the low bits must be zero |
| inData | input | DATA_W | Word from upstream |
| inValid | input | 1 | Upstream word valid |
| inReady | output | 1 | Block takes the word this cycle |
| memWait | input | 1 | Memory stalls the current transfer |
| memAddr | output | ADDR_W | Byte address of the write |
| memWrData | output | DATA_W | Write data |
| memWrite | output | 1 | Write request |
| memByteEn | output | DATA_W/8 | Byte enables, all ones |
| memBurst | output | BURST_W | Burst count, fixed at 1 |
| irq | output | 1 | A buffer holds a complete packet |
| irqBuf | output | 1 | Index of the oldest complete buffer |
| irqAck | input | 1 | Host releases the buffer named by irqBuf |
| overflow | output | 1 | Sticky: data arrived while both buffers were full |

## Verification
The hardest state to reach from the ports is the one where both buffers are full at once while the producer is still pushing data. Only in that state are the ready gating and the sticky overflow flag active. Random traffic with a host that acknowledges promptly rarely gets there. For that reason a directed phase holds `irqAck` low and `memWait` low with `inValid` high until two whole packets have landed. It then releases the buffers one at a time and sends extra acknowledges with nothing pending. Random phases also let a packet boundary fall on a cycle where a write is accepted and a new word is taken at the same time, which exercises the buffer switch on the same clock.

// File: rtl/pingpong_wr_pkg.sv
package pingpong_wr_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new upstream word and raise write
    logic retire;  // current write accepted by memory
  } wrStrobe_t;
endpackage

// File: rtl/pingpong_wr_ctrl.sv
module pingpong_wr_ctrl
  import pingpong_wr_pkg::*;
#(
  parameter int PKT_WORDS = 1157,
  parameter int IDX_W     = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             inValid,
  input  logic             memWait,
  input  logic             memBusy,
  input  logic             irqAck,
  output logic             inReady,
  output wrStrobe_t        strb,
  output logic             bufSel,
  output logic [IDX_W-1:0] wordIdx,
  output logic             irq,
  output logic             irqBuf,
  output logic             overflow
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_WORDS - 1);

  logic [1:0] full, fullNxt;
  logic       ackPtr;
  logic       lastWord, nextSel, retire, load;

  assign retire   = memBusy & ~memWait;
  assign lastWord = (wordIdx == LAST_IDX);
  assign nextSel  = (retire && lastWord) ? ~bufSel : bufSel;
  assign inReady  = enable & ~full[nextSel] & (~memBusy | retire);
  assign load     = inValid & inReady;
  assign strb     = '{load: load, retire: retire};

  always_comb begin
    fullNxt = full;
    if (irqAck && full[ackPtr]) fullNxt[ackPtr] = 1'b0;
    if (retire && lastWord)     fullNxt[bufSel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bufSel   <= 1'b0;
      wordIdx  <= '0;
      full     <= '0;
      ackPtr   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      full <= fullNxt;
      if (irqAck && full[ackPtr]) ackPtr <= ~ackPtr;
      if (retire) begin
        if (lastWord) begin
          wordIdx <= '0;
          bufSel  <= ~bufSel;
        end else begin
          wordIdx <= wordIdx + IDX_W'(1);
        end
      end
      if ((&full) && inValid) overflow <= 1'b1;
    end
  end

  assign irq    = |full;
  assign irqBuf = ackPtr;

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    wordIdx <= LAST_IDX);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    irq && !irqAck |=> irq);

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R9
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (&full) |-> !load);
endmodule

// File: rtl/pingpong_wr_dpath.sv
module pingpong_wr_dpath
  import pingpong_wr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int PKT_WORDS = 1157,
  parameter int IDX_W     = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  wrStrobe_t         strb,
  input  logic [DATA_W-1:0] inData,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              bufSel,
  input  logic [IDX_W-1:0]  wordIdx,
  output logic              memWrite,
  output logic [DATA_W-1:0] memWrData,
  output logic [ADDR_W-1:0] memAddr
);
  localparam int BYTE_SH = $clog2(DATA_W / 8);

  logic [ADDR_W-1:0] slot, offset;

  assign slot    = ADDR_W'(wordIdx) + (bufSel ? ADDR_W'(PKT_WORDS) : '0);
  assign offset  = slot << BYTE_SH;
  assign memAddr = baseAddr | offset;

  always_ff @(posedge clk) begin
    if (rst) begin
      memWrite  <= 1'b0;
      memWrData <= '0;
    end else if (strb.load) begin
      memWrite  <= 1'b1;
      memWrData <= inData;
    end else if (strb.retire) begin
      memWrite  <= 1'b0;
    end
  end
endmodule

// File: rtl/pingpong_wr_master.sv
module pingpong_wr_master
  import pingpong_wr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int BURST_W   = 4,
  parameter int PKT_WORDS = (37000 + DATA_W - 1) / DATA_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enable,
  input  logic [ADDR_W-1:0]     baseAddr,
  input  logic [DATA_W-1:0]     inData,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic                  memWait,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]     memWrData,
  output logic                  memWrite,
  output logic [DATA_W/8-1:0]   memByteEn,
  output logic [BURST_W-1:0]    memBurst,
  output logic                  irq,
  output logic                  irqBuf,
  input  logic                  irqAck,
  output logic                  overflow
);
  localparam int IDX_W = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1;

  wrStrobe_t        strb;
  logic             bufSel;
  logic [IDX_W-1:0] wordIdx;

  pingpong_wr_ctrl #(.PKT_WORDS(PKT_WORDS), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rst(rst), .enable(enable), .inValid(inValid),
    .memWait(memWait), .memBusy(memWrite), .irqAck(irqAck),
    .inReady(inReady), .strb(strb), .bufSel(bufSel), .wordIdx(wordIdx),
    .irq(irq), .irqBuf(irqBuf), .overflow(overflow)
  );

  pingpong_wr_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W),
                      .PKT_WORDS(PKT_WORDS), .IDX_W(IDX_W)) uDpath (
    .clk(clk), .rst(rst), .strb(strb), .inData(inData),
    .baseAddr(baseAddr), .bufSel(bufSel), .wordIdx(wordIdx),
    .memWrite(memWrite), .memWrData(memWrData), .memAddr(memAddr)
  );

  assign memByteEn = '1;
  assign memBurst  = BURST_W'(1);

  // R4
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    memWrite && memWait |=> memWrite && $stable(memAddr) && $stable(memWrData));

  // R5
  drop_write_chk: assert property (@(posedge clk) disable iff (rst)
    memWrite && !memWait && !(inValid && inReady) |=> !memWrite);
endmodule

// File: tb/sim_pingpong_wr_master.sv
`timescale 1ns/1ps
module sim_pingpong_wr_master;
  localparam int DW = 32, AW = 32, BW = 4, PKT = 5, BYTES = DW / 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, enable, inValid, memWait, irqAck;
  logic [AW-1:0] baseAddr = 32'h2800_0000;
  logic [DW-1:0] inData;
  logic inReady, memWrite, irq, irqBuf, overflow;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWrData;
  logic [BYTES-1:0] memByteEn;
  logic [BW-1:0] memBurst;

  pingpong_wr_master #(.DATA_W(DW), .ADDR_W(AW), .BURST_W(BW), .PKT_WORDS(PKT)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .baseAddr(baseAddr),
    .inData(inData), .inValid(inValid), .inReady(inReady), .memWait(memWait),
    .memAddr(memAddr), .memWrData(memWrData), .memWrite(memWrite),
    .memByteEn(memByteEn), .memBurst(memBurst), .irq(irq), .irqBuf(irqBuf),
    .irqAck(irqAck), .overflow(overflow)
  );

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // bench model
  int wordCount;
  logic [1:0] fullM;
  bit ackM, ovfM, prevWait;
  logic [AW-1:0] prevAddr;
  logic [DW-1:0] prevData;
  logic [DW-1:0] q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] expAddr(input int n);
    int b = (n / PKT) % 2;
    int i = n % PKT;
    return baseAddr | AW'((b * PKT + i) * BYTES);
  endfunction

  function automatic bit expReady(input bit en, input bit busy, input bit w);
    int nb = ((wordCount + (busy ? 1 : 0)) / PKT) % 2;
    return en && !fullM[nb] && (!busy || !w);
  endfunction

  task automatic modelReset();
    wordCount = 0; fullM = 2'b00; ackM = 0; ovfM = 0; prevWait = 0;
    q.delete();
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; inValid = 0; memWait = 0; irqAck = 0; enable = 1; inData = '0;
    repeat (2) @(negedge clk);
    rst = 0;
    modelReset();
  endtask

  task automatic step(input bit v, input logic [DW-1:0] d, input bit w,
                      input bit ack, input bit en);
    bit fire, acc, er, busy;
    logic [DW-1:0] front;
    logic [1:0] preFull;
    @(negedge clk);
    chk(irq == (|fullM), "R7", "irq", irq, |fullM);
    if (fullM != 0) chk(irqBuf == ackM, "R8", "irqBuf", irqBuf, ackM);
    chk(overflow == ovfM, "R9", "overflow", overflow, ovfM);
    chk(memWrite == (q.size() > 0), "R5", "pending write", memWrite, q.size());
    if (prevWait) begin
      chk(memWrite == 1'b1, "R4", "write held", memWrite, 1);
      chk(memAddr == prevAddr, "R4", "addr held", memAddr, prevAddr);
      chk(memWrData == prevData, "R4", "data held", memWrData, prevData);
    end
    if (memWrite) chk(memByteEn == '1 && memBurst == BW'(1), "R3", "byteen/burst",
                      {memByteEn, memBurst}, {4'hF, 4'h1});
    inValid = v; inData = d; memWait = w; irqAck = ack; enable = en;
    #1;
    busy = memWrite;
    er = expReady(en, busy, w);
    chk(inReady == er, (fullM == 2'b11) ? "R9" : "R6", "inReady", inReady, er);
    fire = v && inReady;
    acc  = busy && !w;
    preFull = fullM;
    if (ack && preFull[ackM]) begin fullM[ackM] = 1'b0; ackM = ~ackM; end
    if (acc) begin
      if (q.size() == 0) chk(0, "R5", "write with no word", 1, 0);
      else begin
        front = q.pop_front();
        chk(memWrData == front, "R5", "write data", memWrData, front);
      end
      chk(memAddr == expAddr(wordCount), "R2", "write addr", memAddr, expAddr(wordCount));
      if (wordCount % PKT == PKT - 1) fullM[(wordCount / PKT) % 2] = 1'b1;
      wordCount++;
    end
    if (fire) q.push_back(d);
    if (preFull == 2'b11 && v) ovfM = 1;
    prevWait = busy && w;
    prevAddr = memAddr; prevData = memWrData;
  endtask

  task automatic randPhase(input int n);
    for (int k = 0; k < n; k++)
      step($urandom % 4 != 0, $urandom, $urandom % 3 == 0, $urandom % 4 == 0,
           $urandom % 16 != 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    rst = 1; modelReset();
    doReset();
    // R1 reset state
    @(negedge clk); #1;
    chk(memWrite == 0, "R1", "memWrite", memWrite, 0);
    chk(irq == 0, "R1", "irq", irq, 0);
    chk(overflow == 0, "R1", "overflow", overflow, 0);
    chk(inReady == 1, "R1", "inReady", inReady, 1);
    // R6 stopped: nothing taken
    for (int k = 0; k < 3; k++) step(1, 32'hDEAD0000 + k, 0, 0, 0);
    // R4 first word stalls three cycles, then R2 lands at base
    step(1, 32'hA5A5_0001, 1, 0, 1);
    for (int k = 0; k < 3; k++) step(0, 0, 1, 0, 1);
    step(0, 0, 0, 0, 1);
    // random traffic
    randPhase(300);
    // drain pending work and release buffers
    for (int k = 0; k < 6; k++) step(0, 0, 0, 1, 1);
    // R9 host silent: fill both buffers, then keep pushing
    for (int k = 0; k < 4 * PKT + 6; k++) step(1, $urandom, 0, 0, 1);
    chk(fullM == 2'b11 && ovfM, "R9", "both full model", {fullM, ovfM}, 3'b111);
    // R8 release one at a time, then spurious acks
    step(0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 1);
    for (int k = 0; k < 3; k++) step(0, 0, 0, 1, 1);
    chk(irq == 0, "R8", "irq after release", irq, 0);
    randPhase(150);
    // R10 reset mid-run
    doReset();
    @(negedge clk); #1;
    chk(memWrite == 0 && irq == 0 && overflow == 0, "R10", "cleared",
        {memWrite, irq, overflow}, 0);
    step(1, 32'h1234_5678, 0, 0, 1);
    step(0, 0, 0, 0, 1);  // lands at base again (R10, R2)
    randPhase(250);
    for (int k = 0; k < 6; k++) step(0, 0, 0, 1, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule